// File: doc/BRIEF.md
# Circular-Buffer Stereo Audio Serial Transmitter

This block is the master side of a three-wire stereo audio link in the usual I2S format. It produces the bit clock, the word select and the serial data itself. It takes its samples from an external word memory through a synchronous read port. Each memory word holds one stereo pair. The block walks the memory from the first address to the last and then starts again at the first. The output stream has no gap at the wrap.

Software keeps the stream going by refilling whichever half of the memory the block is not currently reading. Each half has its own sticky flag. A flag rises when the block issues the read of the final word in that half. Software clears a flag by pulsing the matching clear input. A one-bit run register starts streaming. Clearing that register lets the current stereo frame finish, then parks the outputs low and rewinds the read pointer to address zero.

Top module: `pcm_ring_tx`

## Requirements
- R1: After reset, `bclk`, `ws`, `sdata`, `irqLo`, `irqHi` and `memRe` are all 0.
- R2: While streaming, `bclk` toggles every `DIV` clock cycles, so one bit lasts `2*DIV` cycles (4 with the default `DIV`=2).
- R3: Each memory word is sent as one 32-bit frame, most significant bit first. Bits 31:16 are the left sample and bits 15:0 are the right sample. `sdata` changes only on the falling edge of `bclk`.
- R4: `ws` is 0 for the left word and 1 for the right word. It switches one bit period before each word's MSB, so it is 1 during frame bits 15..30 and 0 during bit 31 and bits 0..14. `ws` changes only on the falling edge of `bclk`.
- R5: Frames follow memory addresses 0, 1, 2, and so on. After the last address, the next frame comes from address 0, with no idle bit between consecutive frames.
- R6: `irqLo` becomes 1 the cycle after the read of address `DEPTH/2-1` is issued, and it stays 1 until it is cleared.
- R7: `irqHi` becomes 1 the cycle after the read of address `DEPTH-1` is issued, and it stays 1 until it is cleared.
- R8: A one-cycle pulse on `clrLo` or `clrHi` clears the matching flag on the next cycle. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: When `ctlWe` is pulsed with `ctlRun`=0, the frame in progress is sent to its last bit. After that, `bclk`, `ws` and `sdata` stay 0 and no reads are issued. The next start sends the word at address 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctlWe | input | 1 | Write strobe for the run register |
| ctlRun | input | 1 | Run value written when ctlWe is 1 (1 = start, 0 = stop) |
| clrLo | input | 1 | Pulse 1 to clear the first-half flag |
| clrHi | input | 1 | Pulse 1 to clear the second-half flag |
| memRe | output | 1 | Memory read enable |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | 32 | Read data, valid the cycle after memRe |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (0 = left, 1 = right) |
| sdata | output | 1 | Serial data, MSB first |
| irqLo | output | 1 | Sticky flag: first half consumed |
| irqHi | output | 1 | Sticky flag: second half consumed |

## Verification
Each fault in the internal state has a port-level symptom with a bounded delay:
- A slipped bit counter moves the `ws` transitions against the data, and a misplaced load corrupts a frame. Both show in the next frame, within 32 bit periods.
- An off-by-one read pointer delivers a word from the wrong address in the very next frame.
- A broken half-flag comparison shows only when the pointer crosses the half boundary, so the bench streams past both halves and past the wrap.
- A pointer that is not rewound on stop shows in the first frame after the restart.

// File: rtl/pcm_ring_pkg.sv
package pcm_ring_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadMem;   // load shifter straight from read data
    logic loadNext;  // load shifter from prefetched word
    logic shift;     // advance one bit
    logic capture;   // latch read data into prefetch register
    logic clear;     // return shifter to idle
  } dpStrobe_t;
endpackage

// File: rtl/pcm_ring_ctrl.sv
module pcm_ring_ctrl
  import pcm_ring_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int DIV      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWe,
  input  logic              ctlRun,
  input  logic              clrLo,
  input  logic              clrHi,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              bclk,
  output logic              ws,
  output logic              irqLo,
  output logic              irqHi,
  output dpStrobe_t         strobe
);
  localparam int FRAME_BITS = 2 * SAMPLE_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF       = 2 ** (ADDR_W - 1);
  localparam int DEPTH      = 2 ** ADDR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} state_t;

  state_t            state;
  logic              runQ;
  logic [ADDR_W-1:0] ptr;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              bclkQ, wsQ, capPend;
  logic              tick, fall, frameEnd;
  logic [BIT_W-1:0]  nextSlot;

  always_comb begin
    tick     = (state == ST_RUN) && (divCnt == DIV_W'(DIV - 1));
    fall     = tick && bclkQ;
    frameEnd = fall && (bitCnt == BIT_W'(FRAME_BITS - 1));
    nextSlot = bitCnt + 1'b1;
    memRe    = ((state == ST_IDLE) && runQ) || (state == ST_LOAD) || (frameEnd && runQ);
    strobe.loadMem  = (state == ST_LOAD);
    strobe.loadNext = frameEnd && runQ;
    strobe.shift    = fall && !frameEnd;
    strobe.capture  = capPend;
    strobe.clear    = frameEnd && !runQ;
  end

  assign memAddr = ptr;
  assign bclk    = bclkQ;
  assign ws      = wsQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      runQ    <= 1'b0;
      ptr     <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      bclkQ   <= 1'b0;
      wsQ     <= 1'b0;
      capPend <= 1'b0;
      irqLo   <= 1'b0;
      irqHi   <= 1'b0;
    end else begin
      if (ctlWe) runQ <= ctlRun;
      capPend <= memRe && (state != ST_IDLE);

      if (strobe.clear)  ptr <= '0;
      else if (memRe)    ptr <= ptr + 1'b1;

      case (state)
        ST_IDLE: if (runQ) state <= ST_LOAD;
        ST_LOAD: state <= ST_RUN;
        default: if (frameEnd && !runQ) state <= ST_IDLE;
      endcase

      if (state != ST_RUN) begin
        divCnt <= '0;
        bclkQ  <= 1'b0;
        bitCnt <= '0;
        wsQ    <= 1'b0;
      end else if (tick) begin
        divCnt <= '0;
        bclkQ  <= ~bclkQ;
        if (fall) begin
          bitCnt <= nextSlot;
          wsQ    <= (nextSlot >= BIT_W'(SAMPLE_W - 1)) && (nextSlot <= BIT_W'(FRAME_BITS - 2));
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end

      if (memRe && ptr == ADDR_W'(HALF - 1))       irqLo <= 1'b1;
      else if (clrLo)                              irqLo <= 1'b0;
      if (memRe && ptr == ADDR_W'(DEPTH - 1))      irqHi <= 1'b1;
      else if (clrHi)                              irqHi <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_ring_dp.sv
module pcm_ring_dp
  import pcm_ring_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dpStrobe_t               strobe,
  input  logic [2*SAMPLE_W-1:0]   memData,
  output logic                    sdata
);
  localparam int DATA_W = 2 * SAMPLE_W;

  logic [DATA_W-1:0] shiftQ, nextQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftQ <= '0;
      nextQ  <= '0;
    end else begin
      if (strobe.capture) nextQ <= memData;
      if (strobe.clear)         shiftQ <= '0;
      else if (strobe.loadMem)  shiftQ <= memData;
      else if (strobe.loadNext) shiftQ <= nextQ;
      else if (strobe.shift)    shiftQ <= {shiftQ[DATA_W-2:0], 1'b0};
    end
  end

  assign sdata = shiftQ[DATA_W-1];
endmodule

// File: rtl/pcm_ring_tx.sv
module pcm_ring_tx
  import pcm_ring_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int DIV      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctlWe,
  input  logic                  ctlRun,
  input  logic                  clrLo,
  input  logic                  clrHi,
  output logic                  memRe,
  output logic [ADDR_W-1:0]     memAddr,
  input  logic [2*SAMPLE_W-1:0] memData,
  output logic                  bclk,
  output logic                  ws,
  output logic                  sdata,
  output logic                  irqLo,
  output logic                  irqHi
);
  dpStrobe_t strobe;

  pcm_ring_ctrl #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .DIV(DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctlWe(ctlWe), .ctlRun(ctlRun),
    .clrLo(clrLo), .clrHi(clrHi), .memRe(memRe), .memAddr(memAddr),
    .bclk(bclk), .ws(ws), .irqLo(irqLo), .irqHi(irqHi), .strobe(strobe)
  );

  pcm_ring_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .memData(memData), .sdata(sdata)
  );
endmodule

// File: rtl/pcm_ring_tx_chk.sv
module pcm_ring_tx_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              memRe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              bclk,
  input logic              ws,
  input logic              sdata,
  input logic              irqLo,
  input logic              irqHi,
  input logic              clrLo,
  input logic              clrHi
);
  localparam int HALF  = 2 ** (ADDR_W - 1);
  localparam int DEPTH = 2 ** ADDR_W;

  logic setLo, setHi;
  assign setLo = memRe && (memAddr == ADDR_W'(HALF - 1));
  assign setHi = memRe && (memAddr == ADDR_W'(DEPTH - 1));

  assert_sdata_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> !bclk);
  assert_ws_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> !bclk);
  assert_lo_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    setLo |=> irqLo);
  assert_hi_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    setHi |=> irqHi);
  assert_lo_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clrLo && !setLo) |=> !irqLo);
  assert_hi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clrHi && !setHi) |=> !irqHi);
endmodule

bind pcm_ring_tx pcm_ring_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .memRe(memRe), .memAddr(memAddr), .bclk(bclk),
  .ws(ws), .sdata(sdata), .irqLo(irqLo), .irqHi(irqHi), .clrLo(clrLo), .clrHi(clrHi)
);

// File: tb/pcm_ring_tx_bench.sv
module pcm_ring_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int DIV    = 2;

  // checkpoint table: frame index -> expected word (first half refilled after irqLo)
  localparam int          CHK_FRAME [0:7] = '{0, 1, 127, 128, 255, 256, 257, 300};
  localparam logic [31:0] CHK_WORD  [0:7] = '{32'hC3003C00, 32'hC3013C01, 32'hC37F3C7F,
                                              32'hC3803C80, 32'hC3FF3CFF, 32'h5A00A500,
                                              32'h5A01A501, 32'h5A2CA52C};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctlWe = 1'b0, ctlRun = 1'b0, clrLo = 1'b0, clrHi = 1'b0;
  logic memRe, bclk, ws, sdata, irqLo, irqHi;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memData;
  logic [31:0] mem [0:DEPTH-1];

  int checks = 0, fails = 0;
  int bitCount = 0, frameCnt = 0, wsErr = 0, periodErr = 0, cyc = 0, lastRise = 0;
  logic bclkPrev = 1'b0;
  logic [31:0] curWord = '0;
  logic [31:0] frames [0:511];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pcm_ring_tx #(.ADDR_W(ADDR_W), .SAMPLE_W(16), .DIV(DIV)) u_pcm_ring_tx (
    .clk(clk), .rst_n(rst_n), .ctlWe(ctlWe), .ctlRun(ctlRun), .clrLo(clrLo), .clrHi(clrHi),
    .memRe(memRe), .memAddr(memAddr), .memData(memData), .bclk(bclk), .ws(ws),
    .sdata(sdata), .irqLo(irqLo), .irqHi(irqHi)
  );

  always_ff @(posedge clk) if (memRe) memData <= mem[memAddr];

  // serial monitor, sampled away from the clock edge
  always @(negedge clk) begin
    cyc++;
    if (bclk && !bclkPrev) begin
      int slot;
      slot = bitCount % 32;
      if (slot != 0 && (cyc - lastRise) != 2 * DIV) periodErr++;
      lastRise = cyc;
      if (ws != (((slot + 1) % 32) >= 16)) wsErr++;
      curWord = {curWord[30:0], sdata};
      bitCount++;
      if (slot == 31) begin
        if (frameCnt < 512) frames[frameCnt] = curWord;
        frameCnt++;
      end
    end
    bclkPrev = bclk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    while (frameCnt < n) @(negedge clk);
  endtask

  task automatic setRun(input logic v);
    @(negedge clk); ctlWe = 1'b1; ctlRun = v;
    @(negedge clk); ctlWe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int f0, f1;
    for (int i = 0; i < DEPTH; i++) mem[i] = {16'hC300 | 16'(i), 16'h3C00 | 16'(i)};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bclk", 32'(bclk), 0);
    check("R1 ws", 32'(ws), 0);
    check("R1 sdata", 32'(sdata), 0);
    check("R1 irqLo", 32'(irqLo), 0);
    check("R1 irqHi", 32'(irqHi), 0);
    check("R1 memRe", 32'(memRe), 0);
    rst_n = 1'b1;
    setRun(1'b1);

    // R6: refill first half once it has been consumed
    while (!irqLo) @(negedge clk);
    check("R6 irqLo set", 32'(irqLo), 1);
    check("R6 irqLo raised after frame 120", 32'(frameCnt >= 120 && frameCnt <= 127), 1);
    for (int i = 0; i < DEPTH / 2; i++) mem[i] = {16'h5A00 | 16'(i), 16'hA500 | 16'(i)};
    clrLo = 1'b1; @(negedge clk); clrLo = 1'b0;
    check("R8 irqLo cleared", 32'(irqLo), 0);

    waitFrames(302);
    check("R7 irqHi set", 32'(irqHi), 1);
    clrHi = 1'b1; @(negedge clk); clrHi = 1'b0;
    check("R8 irqHi cleared", 32'(irqHi), 0);

    // table walk: R3 bit order, R5 sequence and wrap
    for (int k = 0; k < 8; k++)
      check($sformatf("R3/R5 frame %0d", CHK_FRAME[k]), frames[CHK_FRAME[k]], CHK_WORD[k]);
    check("R4 ws alignment errors", 32'(wsErr), 0);
    check("R2 bit period errors", 32'(periodErr), 0);

    // R9: stop mid-frame
    while (bitCount % 32 != 5) @(negedge clk);
    f0 = frameCnt;
    setRun(1'b0);
    repeat (400) @(negedge clk);
    begin
      int reads;
      reads = 0;
      for (int i = 0; i < 400; i++) begin @(negedge clk); if (memRe) reads++; end
      check("R9 no reads while stopped", 32'(reads), 0);
    end
    check("R9 frame finished", 32'(frameCnt), 32'(f0 + 1));
    check("R9 whole frames only", 32'(bitCount % 32), 0);
    check("R9 idle outputs", {29'd0, bclk, ws, sdata}, 0);

    f1 = frameCnt;
    setRun(1'b1);
    waitFrames(f1 + 2);
    check("R9 restart from address 0", frames[f1], 32'h5A00A500);
    check("R9 restart second word", frames[f1 + 1], 32'h5A01A501);
    check("R4 ws alignment after restart", 32'(wsErr), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule